// File: doc/BRIEF.md
# Two-Bank Dual-Port Word Memory

This block is a true dual-port synchronous word memory that shares one clock between its ports. By default it stores 2048 words of 32 bits. The storage is two identical dual-port banks of 1024 words each. Glue logic joins them, and each port, A and B, has its own copy of that logic.

On every port, one address bit picks the bank and the bits below it pick the word inside that bank. A write strobes only the chosen bank. Reads have one cycle of latency. The bank choice is therefore registered next to the read, so that the output multiplexer follows the bank the port addressed in the previous cycle.

For simulation, a parameter can fill the contents with a known pattern. Both ports can work on any words at the same time. A same-word write collision is settled in favour of port A.

Top module: `dual_bank_ram`

## Requirements
- R1: Address bit WORD_BITS selects the bank (0 = lower, 1 = upper) and bits WORD_BITS-1..0 select the word inside it, giving 2·2^WORD_BITS distinct words reachable from either port.
- R2: Read data for the address presented before a rising clock edge appears on that port's dout after that edge, and dout holds its previous value until that edge.
- R3: A write changes only the addressed word of the selected bank. The same word index in the other bank keeps its contents, and no bank write strobe is raised without a port write.
- R4: Both ports operate in the same cycle on different words without disturbing each other.
- R5: A read of a word that is being written in the same cycle, by either port, returns the contents from before the write.
- R6: When both ports write the same word in the same cycle, the word afterwards holds port A's data.
- R7: Address bits above WORD_BITS are ignored, so an address wraps onto its low WORD_BITS+1 bits.
- R8: While rst is high, both dout ports read as zero and no write takes effect.
- R9: With INIT_MODE = 1, the word at global address g starts out holding g truncated to WIDTH bits. With INIT_MODE = 0, every word starts out as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rst | input | 1 | Synchronous active-high reset of the read path |
| aWe | input | 1 | Port A write enable |
| aAddr | input | ADDR_W | Port A word address |
| aDin | input | WIDTH | Port A write data |
| aDout | output | WIDTH | Port A read data, one cycle after the address |
| bWe | input | 1 | Port B write enable |
| bAddr | input | ADDR_W | Port B word address |
| bDin | input | WIDTH | Port B write data |
| bDout | output | WIDTH | Port B read data, one cycle after the address |

## Verification
The bench builds the block with WORD_BITS = 4, WIDTH = 16, ADDR_W = 8 and INIT_MODE = 1. That gives 16 words per bank, 32 in total. At this size every word in both banks can be swept from both ports: first against the preloaded address pattern, then against arithmetic write patterns, with the two ports always pointed at different banks or words. Because the 8-bit address is wider than the 5 bits actually used, aliases above the decoded range can be tried. The small size also leaves cycles to force same-word collisions and read-during-write cases directly.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int NUM_PORTS = 2;  // index 0 = port A, 1 = port B
  localparam int NUM_BANKS = 2;

  typedef struct packed {
    logic [NUM_PORTS-1:0][NUM_BANKS-1:0] bankWe;  // per port, per bank write strobe
    logic [NUM_PORTS-1:0]                selQ;    // registered bank choice per port
  } ctl_strobe_t;
endpackage

// File: rtl/dbr_bank.sv
module dbr_bank #(
  parameter int WORD_BITS = 10,
  parameter int WIDTH     = 32,
  parameter int BANK_ID   = 0,
  parameter int INIT_MODE = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 weA,
  input  logic [WORD_BITS-1:0] addrA,
  input  logic [WIDTH-1:0]     dinA,
  output logic [WIDTH-1:0]     rdA,
  input  logic                 weB,
  input  logic [WORD_BITS-1:0] addrB,
  input  logic [WIDTH-1:0]     dinB,
  output logic [WIDTH-1:0]     rdB
);
  localparam int DEPTH = 1 << WORD_BITS;

  logic [WIDTH-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = (INIT_MODE == 1) ? WIDTH'((BANK_ID * DEPTH) + i) : '0;
    end
  end

  // Reads see the old contents; port A's write is scheduled last so it wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdA <= '0;
      rdB <= '0;
    end else begin
      rdA <= mem[addrA];
      rdB <= mem[addrB];
    end
    if (weB) mem[addrB] <= dinB;
    if (weA) mem[addrA] <= dinA;
  end
endmodule

// File: rtl/dbr_ctrl.sv
module dbr_ctrl
  import dbr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] portWe,
  input  logic [NUM_PORTS-1:0] bankBit,
  output ctl_strobe_t          strobe
);
  logic [NUM_PORTS-1:0] selQ;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb begin
      strobe.bankWe[p] = '0;
      if (portWe[p] && !rst) strobe.bankWe[p][bankBit[p]] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) selQ[p] <= 1'b0;
      else     selQ[p] <= bankBit[p];
    end
  end

  assign strobe.selQ = selQ;
endmodule

// File: rtl/dbr_datapath.sv
module dbr_datapath
  import dbr_pkg::*;
#(
  parameter int WORD_BITS = 10,
  parameter int WIDTH     = 32,
  parameter int INIT_MODE = 0
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  ctl_strobe_t                          strobe,
  input  logic [NUM_PORTS-1:0][WORD_BITS-1:0] wordAddr,
  input  logic [NUM_PORTS-1:0][WIDTH-1:0]     din,
  output logic [NUM_PORTS-1:0][WIDTH-1:0]     dout
);
  logic [NUM_BANKS-1:0][NUM_PORTS-1:0][WIDTH-1:0] rdData;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dbr_bank #(
      .WORD_BITS(WORD_BITS),
      .WIDTH    (WIDTH),
      .BANK_ID  (b),
      .INIT_MODE(INIT_MODE)
    ) uBank (
      .clk  (clk),
      .rst  (rst),
      .weA  (strobe.bankWe[0][b]),
      .addrA(wordAddr[0]),
      .dinA (din[0]),
      .rdA  (rdData[b][0]),
      .weB  (strobe.bankWe[1][b]),
      .addrB(wordAddr[1]),
      .dinB (din[1]),
      .rdB  (rdData[b][1])
    );
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mux
    assign dout[p] = rdData[strobe.selQ[p]][p];
  end
endmodule

// File: rtl/dual_bank_ram.sv
module dual_bank_ram
  import dbr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_BITS = 10,
  parameter int WIDTH     = 32,
  parameter int INIT_MODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [WIDTH-1:0]  aDin,
  output logic [WIDTH-1:0]  aDout,
  input  logic              bWe,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [WIDTH-1:0]  bDin,
  output logic [WIDTH-1:0]  bDout
);
  ctl_strobe_t                          ctlStrobe;
  logic [NUM_PORTS-1:0][WORD_BITS-1:0] wordAddr;
  logic [NUM_PORTS-1:0][WIDTH-1:0]     dinBus;
  logic [NUM_PORTS-1:0][WIDTH-1:0]     doutBus;

  assign wordAddr = {bAddr[WORD_BITS-1:0], aAddr[WORD_BITS-1:0]};
  assign dinBus   = {bDin, aDin};
  assign aDout    = doutBus[0];
  assign bDout    = doutBus[1];

  if (ADDR_W > WORD_BITS + 1) begin : g_wrap
    logic unusedHigh;
    assign unusedHigh = ^{aAddr[ADDR_W-1:WORD_BITS+1], bAddr[ADDR_W-1:WORD_BITS+1]};
  end

  dbr_ctrl uCtrl (
    .clk    (clk),
    .rst    (rst),
    .portWe ({bWe, aWe}),
    .bankBit({bAddr[WORD_BITS], aAddr[WORD_BITS]}),
    .strobe (ctlStrobe)
  );

  dbr_datapath #(
    .WORD_BITS(WORD_BITS),
    .WIDTH    (WIDTH),
    .INIT_MODE(INIT_MODE)
  ) uPath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (ctlStrobe),
    .wordAddr(wordAddr),
    .din     (dinBus),
    .dout    (doutBus)
  );
endmodule

// File: rtl/dual_bank_ram_chk.sv
module dual_bank_ram_chk
  import dbr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             aWe,
  input logic             aBank,
  input logic             bWe,
  input logic             bBank,
  input logic [WIDTH-1:0] aDout,
  input logic [WIDTH-1:0] bDout,
  input ctl_strobe_t      ctlStrobe
);
  logic rstQ = 1'b0;

  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rstQ) begin
      p_reset_clear_r8: assert (aDout == '0 && bDout == '0)
        else $error("dout not cleared under reset");
    end
  end

  p_we_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctlStrobe.bankWe[0]) && $onehot0(ctlStrobe.bankWe[1]));

  p_no_stray_we_r3: assert property (@(posedge clk) disable iff (rst)
    (!aWe |-> ctlStrobe.bankWe[0] == '0) and (!bWe |-> ctlStrobe.bankWe[1] == '0));

  p_we_route_a_r1: assert property (@(posedge clk) disable iff (rst)
    aWe |-> ctlStrobe.bankWe[0][aBank]);

  p_we_route_b_r1: assert property (@(posedge clk) disable iff (rst)
    bWe |-> ctlStrobe.bankWe[1][bBank]);

  p_sel_track_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (ctlStrobe.selQ[0] == $past(aBank)) && (ctlStrobe.selQ[1] == $past(bBank)));
endmodule

bind dual_bank_ram dual_bank_ram_chk #(.WIDTH(WIDTH)) uChk (
  .clk      (clk),
  .rst      (rst),
  .aWe      (aWe),
  .aBank    (aAddr[WORD_BITS]),
  .bWe      (bWe),
  .bBank    (bAddr[WORD_BITS]),
  .aDout    (aDout),
  .bDout    (bDout),
  .ctlStrobe(ctlStrobe)
);

// File: tb/sim_dual_bank_ram.sv
`timescale 1ns/1ps
module sim_dual_bank_ram;
  localparam int AW = 8;
  localparam int WB = 4;
  localparam int W  = 16;
  localparam int TOTAL = 2 << WB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aWe = 1'b0, bWe = 1'b0;
  logic [AW-1:0] aAddr = '0, bAddr = '0;
  logic [W-1:0]  aDin = '0, bDin = '0;
  logic [W-1:0]  aDout, bDout;

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;
  logic [W-1:0] expMem [TOTAL];

  always #5 clk = ~clk;

  dual_bank_ram #(.ADDR_W(AW), .WORD_BITS(WB), .WIDTH(W), .INIT_MODE(1)) u0 (
    .clk(clk), .rst(rst),
    .aWe(aWe), .aAddr(aAddr), .aDin(aDin), .aDout(aDout),
    .bWe(bWe), .bAddr(bAddr), .bDin(bDin), .bDout(bDout)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, then sample 1 ns after the next rising edge.
  task automatic step(input logic aw, input logic [AW-1:0] aa, input logic [W-1:0] ad,
                      input logic bw, input logic [AW-1:0] ba, input logic [W-1:0] bd);
    @(negedge clk);
    aWe = aw; aAddr = aa; aDin = ad;
    bWe = bw; bAddr = ba; bDin = bd;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [W-1:0] pat(input int x);
    return W'(16'hA000 ^ (x * 97));
  endfunction

  initial begin
    for (int i = 0; i < TOTAL; i++) expMem[i] = W'(i);
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset dout A", aDout, '0);
    chk("R8 reset dout B", bDout, '0);
    // A write under reset must not land (R8)
    step(1'b1, 8'd6, 16'hDEAD, 1'b0, 8'd0, '0);
    chk("R8 dout A still zero", aDout, '0);
    @(negedge clk);
    rst = 1'b0; aWe = 1'b0;

    // Preload sweep, ports in opposite directions (R9, R1)
    for (int i = 0; i < TOTAL; i++) begin
      step(1'b0, AW'(i), '0, 1'b0, AW'(TOTAL-1-i), '0);
      chk("R9 preload A", aDout, expMem[i]);
      chk("R9 preload B", bDout, expMem[TOTAL-1-i]);
    end

    // Simultaneous writes: A on even words, B on odd words (R4)
    for (int i = 0; i < TOTAL/2; i++) begin
      step(1'b1, AW'(2*i), pat(2*i), 1'b1, AW'(2*i+1), pat(2*i+1));
      expMem[2*i] = pat(2*i);
      expMem[2*i+1] = pat(2*i+1);
    end
    for (int i = 0; i < TOTAL; i++) begin
      step(1'b0, AW'(i), '0, 1'b0, AW'((i+7) % TOTAL), '0);
      chk("R4 readback A", aDout, expMem[i]);
      chk("R1 readback B", bDout, expMem[(i+7) % TOTAL]);
    end

    // Upper-bank word 2 write leaves lower-bank word 2 alone (R3)
    step(1'b1, AW'((TOTAL/2)+2), 16'h1234, 1'b0, 8'd0, '0);
    expMem[(TOTAL/2)+2] = 16'h1234;
    step(1'b0, 8'd2, '0, 1'b0, AW'((TOTAL/2)+2), '0);
    chk("R3 other bank untouched", aDout, expMem[2]);
    chk("R3 written word", bDout, 16'h1234);

    // Read during write returns old data on both ports (R5)
    step(1'b1, 8'd5, 16'hBEEF, 1'b0, 8'd5, '0);
    chk("R5 same-port old data", aDout, expMem[5]);
    chk("R5 cross-port old data", bDout, expMem[5]);
    expMem[5] = 16'hBEEF;
    step(1'b0, 8'd5, '0, 1'b0, 8'd0, '0);
    chk("R5 new data visible", aDout, 16'hBEEF);

    // Same-word collision: port A wins (R6)
    step(1'b1, 8'd9, 16'h1111, 1'b1, 8'd9, 16'h2222);
    step(1'b0, 8'd9, '0, 1'b0, 8'd9, '0);
    chk("R6 A wins via A", aDout, 16'h1111);
    chk("R6 A wins via B", bDout, 16'h1111);

    // Address wrap (R7): 0xE3 aliases word 3
    step(1'b1, 8'hE3, 16'h7777, 1'b0, 8'd0, '0);
    step(1'b0, 8'd3, '0, 1'b0, 8'h63, '0);
    chk("R7 wrap direct", aDout, 16'h7777);
    chk("R7 wrap alias", bDout, 16'h7777);
    expMem[3] = 16'h7777;

    // Latency: dout holds until the edge, then updates (R2)
    step(1'b0, 8'd10, '0, 1'b0, 8'd20, '0);
    chk("R2 first read", aDout, expMem[10]);
    @(negedge clk);
    aAddr = 8'd20; bAddr = 8'd10;
    #1;
    chk("R2 hold before edge A", aDout, expMem[10]);
    chk("R2 hold before edge B", bDout, expMem[20]);
    @(posedge clk);
    #1;
    chk("R2 after edge A", aDout, expMem[20]);
    chk("R2 after edge B", bDout, expMem[10]);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end
endmodule